// File: doc/BRIEF.md
# Shared-Estimator Probabilistic Flow Counter

This block keeps a small counter for each of a set of flows. A counter does not hold a binary count. It holds a short index into one table of estimate values, and every flow shares that table. The values in the table rise strictly from zero. The number a flow reports is the table value at its index. When an event arrives for a flow, the index moves up by one with probability 1/D, where D is the gap between the current table value and the next one. This keeps the expected estimate equal to the true number of events. A narrow index can therefore cover a wide range of counts, at a relative error that the contents of the table set.

Events arrive as a valid strobe with a flow number, at most one per cycle. Each event runs through a two-cycle read-modify-write. When a later event, or a read, targets the flow whose update is still in flight, the pending result is forwarded to it. A host writes the estimate table through a simple write port while no events are flowing. Estimates are unsigned 32-bit fixed point with 8 fractional bits. Randomness comes from a free-running 32-bit LFSR. An increment is accepted when rand × D_fix < 2^40, so no divider is needed.

Top module: `pfc_counter`

## Requirements
- R1: After reset, every flow reads back estimate 0 with the overflow flag clear, and rd_valid is low until the first read.
- R2: After reset the table holds A_i = i × 256, meaning i.0 in 8-bit fixed point. Until the table is rewritten, each event therefore adds exactly 256 to its flow's estimate.
- R3: A read request sampled at a clock edge produces rd_valid at the next edge. It returns rd_estimate = A[index of the flow] and rd_ovf = that flow's overflow flag. No request means rd_valid is low.
- R4: An event whose gap A[p+1] − A[p] is at most 256 (1.0) always advances the index when p is below the last entry.
- R5: In general an event advances the index by exactly one or leaves it unchanged. An advance happens with probability 1/gap. Over many events the mean estimate tracks the true event count.
- R6: An event that finds a flow's index at the last entry (TBL_DEPTH−1) leaves the index unchanged and sets that flow's overflow flag. The flag stays set until reset. An index that reaches the last entry without a further event leaves the flag clear.
- R7: Events to the same flow on consecutive cycles are all counted. A read issued in the cycle after an event already reflects that event.
- R8: A table write with tbl_we high stores tbl_data at tbl_addr when tbl_addr is not 0. A write to address 0 is ignored, so entry 0 stays 0.
- R9: An event changes only the counter of the flow it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | An event is present this cycle |
| ev_flow | input | FLOW_W | Flow number of the event |
| rd_en | input | 1 | Read request for rd_flow |
| rd_flow | input | FLOW_W | Flow to read |
| rd_valid | output | 1 | Read result valid, one cycle after rd_en |
| rd_estimate | output | 32 | Estimate of the flow read, 8 fractional bits |
| rd_ovf | output | 1 | Sticky overflow flag of the flow read |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | PTR_W | Table entry to write |
| tbl_data | input | 32 | Estimate value to store |

## Verification
Two situations are the hardest to reach from the ports. The first is an event that lands while the same flow's previous update is still in flight. The stimulus reaches it with bursts to one flow on consecutive cycles, with alternating pairs of flows, and with a read placed directly behind the last event. Under the identity table every one of these results is exact. The second is the probabilistic path, which cannot be predicted one event at a time. The bench loads a squares table and interleaves forty events to each of ten fresh flows. It then checks that the mean estimate lands in a window around forty. A stuck-accept or a stuck-reject update would push that mean far outside the window.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int EST_W  = 32;
    localparam int FRAC_W = 8;
    localparam int RAND_W = 32;

    typedef logic [EST_W-1:0]  est_t;
    typedef logic [RAND_W-1:0] rnd_t;

    localparam est_t ONE_FIX = est_t'(1) << FRAC_W;
endpackage

// File: rtl/pfc_lfsr.sv
module pfc_lfsr
    import pfc_pkg::*;
#(
    parameter rnd_t TAPS = 32'h8020_0003,
    parameter rnd_t SEED = 32'h1ACE_B00C
) (
    input  logic clk,
    input  logic rst_n,
    output rnd_t rnd
);
    typedef struct packed {
        rnd_t st;
    } lf_t;

    lf_t q, d;

    always_comb begin
        d = q;
        d.st = {1'b0, q.st[RAND_W-1:1]} ^ (q.st[0] ? TAPS : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.st <= SEED;
        else        q <= d;
    end

    assign rnd = q.st;

    // R5: the random source never locks up in the all-zero state
    p_lfsr_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.st != '0);
endmodule

// File: rtl/pfc_est_table.sv
module pfc_est_table
    import pfc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  est_t             wr_data,
    input  logic [PTR_W-1:0] step_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    output est_t             step_cur,
    output est_t             step_nxt,
    output est_t             rd_val
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][EST_W-1:0] ent;
    } tb_t;

    function automatic tb_t ident_table();
        tb_t t;
        for (int i = 0; i < DEPTH; i++) t.ent[i] = est_t'(i) << FRAC_W;
        return t;
    endfunction

    localparam tb_t RESET_VAL = ident_table();

    tb_t q, d;

    always_comb begin
        d = q;
        if (wr_en && wr_addr != '0) d.ent[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

    assign step_cur = q.ent[step_ptr];
    assign step_nxt = (step_ptr == LAST) ? q.ent[step_ptr] : q.ent[step_ptr + 1'b1];
    assign rd_val   = q.ent[rd_ptr];

    // R8: entry 0 is never written away from zero
    p_entry0_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.ent[0] == '0);
endmodule

// File: rtl/pfc_step_unit.sv
module pfc_step_unit
    import pfc_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic             ovf,
    input  logic             at_last,
    input  est_t             cur,
    input  est_t             nxt,
    input  rnd_t             rnd,
    output logic [PTR_W-1:0] ptr_n,
    output logic             ovf_n
);
    localparam int PROD_W = RAND_W + EST_W;
    localparam int ACC_SH = RAND_W + FRAC_W;

    est_t              gap;
    logic [PROD_W-1:0] prod;
    logic              accept;

    always_comb begin
        gap    = nxt - cur;
        prod   = PROD_W'(rnd) * PROD_W'(gap);
        accept = (prod >> ACC_SH) == '0;
        if (at_last) begin
            ptr_n = ptr;
            ovf_n = 1'b1;
        end else begin
            ptr_n = accept ? ptr + 1'b1 : ptr;
            ovf_n = ovf;
        end
    end
endmodule

// File: rtl/pfc_counter.sv
module pfc_counter
    import pfc_pkg::*;
#(
    parameter int   NUM_FLOWS = 16,
    parameter int   TBL_DEPTH = 16,
    parameter int   FLOW_W    = $clog2(NUM_FLOWS),
    parameter int   PTR_W     = $clog2(TBL_DEPTH),
    parameter rnd_t SEED      = 32'h1ACE_B00C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [FLOW_W-1:0] ev_flow,
    input  logic              rd_en,
    input  logic [FLOW_W-1:0] rd_flow,
    output logic              rd_valid,
    output logic [EST_W-1:0]  rd_estimate,
    output logic              rd_ovf,
    input  logic              tbl_we,
    input  logic [PTR_W-1:0]  tbl_addr,
    input  logic [EST_W-1:0]  tbl_data
);
    localparam logic [PTR_W-1:0] MAX_PTR = PTR_W'(TBL_DEPTH - 1);

    typedef struct packed {
        logic [NUM_FLOWS-1:0][PTR_W-1:0] ptr;
        logic [NUM_FLOWS-1:0]            ovf;
        logic                            s1_vld;
        logic [FLOW_W-1:0]               s1_flow;
        logic [PTR_W-1:0]                s1_ptr;
        logic                            s1_ovf;
        logic                            rd_vld;
        est_t                            rd_est;
        logic                            rd_ovf;
    } st_t;

    st_t q, d;

    rnd_t             rnd;
    est_t             step_cur, step_nxt, tbl_rd_val;
    logic [PTR_W-1:0] step_ptr_n, rd_look_ptr;
    logic             step_ovf_n, rd_look_ovf;
    logic             fwd_ev, fwd_rd;
    logic [PTR_W-1:0] ev_ptr;
    logic             ev_ovf;

    pfc_lfsr #(.SEED(SEED)) u_lfsr (
        .clk (clk),
        .rst_n (rst_n),
        .rnd (rnd)
    );

    pfc_est_table #(.DEPTH(TBL_DEPTH), .PTR_W(PTR_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_addr  (tbl_addr),
        .wr_data  (tbl_data),
        .step_ptr (q.s1_ptr),
        .rd_ptr   (rd_look_ptr),
        .step_cur (step_cur),
        .step_nxt (step_nxt),
        .rd_val   (tbl_rd_val)
    );

    pfc_step_unit #(.PTR_W(PTR_W)) u_step (
        .ptr     (q.s1_ptr),
        .ovf     (q.s1_ovf),
        .at_last (q.s1_ptr == MAX_PTR),
        .cur     (step_cur),
        .nxt     (step_nxt),
        .rnd     (rnd),
        .ptr_n   (step_ptr_n),
        .ovf_n   (step_ovf_n)
    );

    // forwarding from the update in flight, for both the event and the read path
    always_comb begin
        fwd_ev      = q.s1_vld && (q.s1_flow == ev_flow);
        fwd_rd      = q.s1_vld && (q.s1_flow == rd_flow);
        ev_ptr      = fwd_ev ? step_ptr_n : q.ptr[ev_flow];
        ev_ovf      = fwd_ev ? step_ovf_n : q.ovf[ev_flow];
        rd_look_ptr = fwd_rd ? step_ptr_n : q.ptr[rd_flow];
        rd_look_ovf = fwd_rd ? step_ovf_n : q.ovf[rd_flow];
    end

    always_comb begin
        d = q;
        if (q.s1_vld) begin
            d.ptr[q.s1_flow] = step_ptr_n;
            d.ovf[q.s1_flow] = step_ovf_n;
        end
        d.s1_vld  = ev_valid;
        d.s1_flow = ev_flow;
        d.s1_ptr  = ev_ptr;
        d.s1_ovf  = ev_ovf;
        d.rd_vld  = rd_en;
        if (rd_en) begin
            d.rd_est = tbl_rd_val;
            d.rd_ovf = rd_look_ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_valid    = q.rd_vld;
    assign rd_estimate = q.rd_est;
    assign rd_ovf      = q.rd_ovf;

    // R3: a read answers exactly one cycle later
    p_rd_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_rd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R5: a committed index moves by zero or one
    p_step_by_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.s1_vld |=> (q.ptr[$past(q.s1_flow)] == $past(q.s1_ptr)) ||
                     (q.ptr[$past(q.s1_flow)] == PTR_W'($past(q.s1_ptr) + 1'b1)));

    // R4: a gap of at most 1.0 always advances
    p_small_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s1_vld && q.s1_ptr != MAX_PTR && (step_nxt - step_cur) <= ONE_FIX)
        |=> q.ptr[$past(q.s1_flow)] == PTR_W'($past(q.s1_ptr) + 1'b1));

    // R6: an event at the last entry holds the index and flags overflow
    p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s1_vld && q.s1_ptr == MAX_PTR)
        |=> q.ovf[$past(q.s1_flow)] && q.ptr[$past(q.s1_flow)] == MAX_PTR);

    // R6: overflow flags never clear outside reset
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovf & $past(q.ovf)) == $past(q.ovf));
endmodule

// File: tb/pfc_counter_tb.sv
module pfc_counter_tb;
    localparam int NF = 16;
    localparam int ND = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [3:0]  ev_flow = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_flow = '0;
    logic        rd_valid;
    logic [31:0] rd_estimate;
    logic        rd_ovf;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [31:0] tbl_data = '0;

    always #5 clk = ~clk;

    pfc_counter u_dut (
        .clk (clk), .rst_n (rst_n),
        .ev_valid (ev_valid), .ev_flow (ev_flow),
        .rd_en (rd_en), .rd_flow (rd_flow),
        .rd_valid (rd_valid), .rd_estimate (rd_estimate), .rd_ovf (rd_ovf),
        .tbl_we (tbl_we), .tbl_addr (tbl_addr), .tbl_data (tbl_data)
    );

    typedef struct {
        int          flow;
        logic [31:0] est;
        logic        ovf;
        bit          stat;
        string       req;
    } item_t;

    item_t       sb[$];
    int          tests = 0;
    int          fails = 0;
    int          mptr[NF];
    bit          movf[NF];
    logic [31:0] mtbl[ND];
    bit          track = 1'b1;
    longint      stat_sum = 0;
    int          stat_n = 0;
    bit          done = 1'b0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        ev_valid = 1'b0; rd_en = 1'b0; tbl_we = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(negedge clk); quiet(); end
    endtask

    task automatic ev(int f);
        @(negedge clk); quiet();
        ev_valid = 1'b1; ev_flow = 4'(f);
        if (track) begin
            if (mptr[f] == ND - 1) movf[f] = 1'b1;
            else mptr[f]++;
        end
    endtask

    task automatic rd(int f, string req, bit stat);
        item_t it;
        @(negedge clk); quiet();
        rd_en = 1'b1; rd_flow = 4'(f);
        it.flow = f; it.est = mtbl[mptr[f]]; it.ovf = movf[f]; it.stat = stat; it.req = req;
        sb.push_back(it);
    endtask

    task automatic wr(int a, logic [31:0] v);
        @(negedge clk); quiet();
        tbl_we = 1'b1; tbl_addr = 4'(a); tbl_data = v;
        if (a != 0) mtbl[a] = v;
    endtask

    // monitor: compare each read result with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3", "unexpected rd_valid", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (it.stat) begin
                    stat_sum += longint'(rd_estimate);
                    stat_n++;
                end else begin
                    check(rd_estimate == it.est, it.req, $sformatf("estimate flow %0d", it.flow),
                          longint'(rd_estimate), longint'(it.est));
                    check(rd_ovf == it.ovf, it.req, $sformatf("ovf flow %0d", it.flow),
                          longint'(rd_ovf), longint'(it.ovf));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++; tests++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    int stat_flows[10] = '{0, 1, 3, 4, 8, 11, 12, 13, 14, 15};

    initial begin
        for (int i = 0; i < NF; i++) begin mptr[i] = 0; movf[i] = 1'b0; end
        for (int i = 0; i < ND; i++) mtbl[i] = 32'(i) << 8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", longint'(rd_valid), 0);

        // R1: all flows at zero
        for (int f = 0; f < NF; f++) rd(f, "R1", 1'b0);
        idle(2);

        // R2: identity table, spaced events count exactly
        for (int k = 0; k < 3; k++) begin ev(2); idle(3); end
        rd(2, "R2", 1'b0);
        rd(1, "R9", 1'b0);
        rd(3, "R9", 1'b0);
        idle(2);

        // R7: back-to-back events to one flow, read right behind
        for (int k = 0; k < 5; k++) ev(5);
        rd(5, "R7", 1'b0);
        idle(2);
        ev(6); ev(7); ev(6); ev(7); ev(6);
        rd(6, "R7", 1'b0);
        rd(7, "R7", 1'b0);
        idle(2);

        // R6: saturation and sticky overflow; R4: unit gap always advances
        for (int k = 0; k < 17; k++) ev(9);
        for (int k = 0; k < 15; k++) ev(10);
        idle(3);
        rd(9, "R6", 1'b0);
        rd(10, "R6", 1'b0);
        rd(2, "R4", 1'b0);
        idle(3);

        // R8: squares table, address 0 write ignored
        wr(0, 32'h0000_1234);
        for (int i = 1; i < ND; i++) wr(i, 32'(i * i) << 8);
        idle(2);
        rd(9, "R8", 1'b0);
        rd(2, "R8", 1'b0);
        rd(0, "R8", 1'b0);
        idle(2);

        // R5: probabilistic stepping, mean estimate tracks the event count
        track = 1'b0;
        for (int r = 0; r < 40; r++)
            for (int k = 0; k < 10; k++) ev(stat_flows[k]);
        idle(3);
        for (int k = 0; k < 10; k++) rd(stat_flows[k], "R5", 1'b1);
        idle(3);
        check(stat_n == 10, "R5", "statistic reads", stat_n, 10);
        begin
            longint mean_x10;
            mean_x10 = (stat_n > 0) ? (stat_sum * 10) / (longint'(stat_n) * 256) : 0;
            check(mean_x10 >= 150 && mean_x10 <= 650, "R5", "mean estimate x10",
                  mean_x10, 400);
        end
        rd(2, "R9", 1'b0);
        idle(3);
        check(sb.size() == 0, "R3", "pending reads", sb.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule